// File: doc/BRIEF.md
# Dual-Register Bidirectional Bus Transceiver

This block links two W-bit buses, A and B, in either direction. Each direction has its own storage register, and each register has its own capture clock. Register A samples bus A on the rising edge of the A-capture clock. Register B samples bus B on the rising edge of the B-capture clock. Both registers keep capturing whether or not either bus is being driven.

For each direction, a select picks what goes out. Low passes live data from the opposite bus. High passes that direction's stored value. An active-low enable and a direction input decide which bus is driven, if either. With these controls the block can pass data A to B or B to A, store either or both buses, or drive stored data back onto a bus.

Each bus is modelled as an input, an output and an output enable, with tri-state pads left to the pad ring. The block is purely combinational from its data and control inputs to its outputs. There is no flow control: the only storage is the two capture registers, and valid/ready handshaking does not apply.

Top module: `dual_reg_bus_xcvr`

## Requirements
- R1: On every rising edge of `cap_a_clk` with `rst` low, register A loads `a_in`. This happens regardless of `en_n`, `dir` and the selects.
- R2: On every rising edge of `cap_b_clk` with `rst` low, register B loads `b_in`. This happens regardless of `en_n`, `dir` and the selects.
- R3: Reset is synchronous and active high, and each register obeys it only at its own clock edge. A `cap_a_clk` edge with `rst` high clears register A to 0 and leaves register B unchanged, and the reverse holds for `cap_b_clk`.
- R4: `b_out` equals `a_in` when `sel_ab` is 0 (live) and equals register A when `sel_ab` is 1 (stored). This holds whether or not `b_oe` is asserted.
- R5: `a_out` equals `b_in` when `sel_ba` is 0 (live) and equals register B when `sel_ba` is 1 (stored). This holds whether or not `a_oe` is asserted.
- R6: With `en_n` = 0 and `dir` = 1, `b_oe` = 1 and `a_oe` = 0, so the A-to-B path drives bus B.
- R7: With `en_n` = 0 and `dir` = 0, `a_oe` = 1 and `b_oe` = 0, so the B-to-A path drives bus A.
- R8: With `en_n` = 1, `a_oe` = `b_oe` = 0 for either `dir`, and both registers still capture as in R1 and R2.
- R9: A change of select alone updates its output in the same cycle, with no registered delay. At every sampled instant each output equals one of its two sources: the live opposite bus or the stored register.
- R10: The selects are independent. `sel_ab` has no effect on `a_out`, and `sel_ba` has no effect on `b_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_a_clk | input | 1 | Capture clock for register A |
| cap_b_clk | input | 1 | Capture clock for register B |
| rst | input | 1 | Synchronous active-high reset, sampled by each capture clock |
| en_n | input | 1 | Active-low output enable |
| dir | input | 1 | 1 drives bus B, 0 drives bus A |
| sel_ab | input | 1 | A-to-B source: 0 live, 1 stored |
| sel_ba | input | 1 | B-to-A source: 0 live, 1 stored |
| a_in | input | W | Bus A input data |
| b_in | input | W | Bus B input data |
| a_out | output | W | Data driven toward bus A |
| a_oe | output | 1 | Output enable for bus A |
| b_out | output | W | Data driven toward bus B |
| b_oe | output | 1 | Output enable for bus B |

## Verification
On every capture clock edge the assertions check the following:
- each register loads its bus, or clears under reset, independently of the other register;
- the output enables are mutually exclusive, and exactly one is on while enabled;
- each output equals one of its two permitted sources.

Only the bench's scenarios can show that the right source is chosen for each select value. The same applies to the selects staying independent, to captures made while both outputs are off coming out later, and to a reset on one clock leaving the other register intact. The bench covers these by sweeping every combination of enable, direction and both selects against a behavioural model.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    DRIVE_NONE  = 2'b00,
    DRIVE_BUS_A = 2'b01,
    DRIVE_BUS_B = 2'b10
  } drive_e;

  function automatic drive_e decode_drive(input logic en_n, input logic dir);
    if (en_n) return DRIVE_NONE;
    return dir ? DRIVE_BUS_B : DRIVE_BUS_A;
  endfunction
endpackage

// File: rtl/capture_reg.sv
module capture_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/hazard_free_mux.sv
module hazard_free_mux #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  // The consensus term keeps a bit high while sel switches, provided both sources agree on it.
  logic [W-1:0] sel_v;
  assign sel_v = {W{sel}};
  assign y = (live & ~sel_v) | (stored & sel_v) | (live & stored);
endmodule

// File: rtl/drive_ctrl.sv
module drive_ctrl
  import xcvr_pkg::*;
(
  input  logic en_n,
  input  logic dir,
  output logic a_oe,
  output logic b_oe
);
  drive_e mode;
  always_comb begin
    mode = decode_drive(en_n, dir);
    a_oe = (mode == DRIVE_BUS_A);
    b_oe = (mode == DRIVE_BUS_B);
  end
endmodule

// File: rtl/dual_reg_bus_xcvr.sv
module dual_reg_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         cap_a_clk,
  input  logic         cap_b_clk,
  input  logic         rst,
  input  logic         en_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic         a_oe,
  output logic [W-1:0] b_out,
  output logic         b_oe
);
  localparam int NDIR = 2;

  logic [NDIR-1:0]        cap_clk;
  logic [NDIR-1:0]        path_sel;
  logic [NDIR-1:0][W-1:0] bus_in;
  logic [NDIR-1:0][W-1:0] stored;
  logic [NDIR-1:0][W-1:0] path_out;

  // Index 0 is the A side (register A, driving bus B); index 1 is the B side.
  assign cap_clk  = {cap_b_clk, cap_a_clk};
  assign path_sel = {sel_ba, sel_ab};
  assign bus_in   = {b_in, a_in};

  for (genvar i = 0; i < NDIR; i++) begin : g_side
    capture_reg #(.W(W)) u_reg (
      .clk (cap_clk[i]),
      .rst (rst),
      .d   (bus_in[i]),
      .q   (stored[i])
    );
    hazard_free_mux #(.W(W)) u_mux (
      .sel    (path_sel[i]),
      .live   (bus_in[i]),
      .stored (stored[i]),
      .y      (path_out[i])
    );
  end

  assign b_out = path_out[0];
  assign a_out = path_out[1];

  drive_ctrl u_drive (
    .en_n (en_n),
    .dir  (dir),
    .a_oe (a_oe),
    .b_oe (b_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         cap_a_clk,
  input logic         cap_b_clk,
  input logic         rst,
  input logic         en_n,
  input logic         dir,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] reg_a,
  input logic [W-1:0] reg_b,
  input logic [W-1:0] a_out,
  input logic         a_oe,
  input logic [W-1:0] b_out,
  input logic         b_oe
);
  p_capture_a_r1: assert property (@(posedge cap_a_clk) disable iff (rst)
    !rst |=> reg_a == $past(a_in));

  p_capture_b_r2: assert property (@(posedge cap_b_clk) disable iff (rst)
    !rst |=> reg_b == $past(b_in));

  p_reset_a_r3: assert property (@(posedge cap_a_clk)
    rst |=> reg_a == '0);

  p_reset_b_r3: assert property (@(posedge cap_b_clk)
    rst |=> reg_b == '0);

  p_oe_exclusive_r8: assert property (@(posedge cap_a_clk) disable iff (rst)
    $onehot0({a_oe, b_oe}));

  p_drive_b_r6: assert property (@(posedge cap_a_clk) disable iff (rst)
    (!en_n && dir) |-> (b_oe && !a_oe));

  p_drive_a_r7: assert property (@(posedge cap_b_clk) disable iff (rst)
    (!en_n && !dir) |-> (a_oe && !b_oe));

  p_disabled_r8: assert property (@(posedge cap_b_clk) disable iff (rst)
    en_n |-> (!a_oe && !b_oe));

  p_b_source_r9: assert property (@(posedge cap_b_clk) disable iff (rst)
    !rst |-> (b_out == a_in || b_out == reg_a));

  p_a_source_r9: assert property (@(posedge cap_a_clk) disable iff (rst)
    !rst |-> (a_out == b_in || a_out == reg_b));
endmodule

bind dual_reg_bus_xcvr xcvr_checker #(.W(W)) u_chk (
  .cap_a_clk (cap_a_clk),
  .cap_b_clk (cap_b_clk),
  .rst       (rst),
  .en_n      (en_n),
  .dir       (dir),
  .a_in      (a_in),
  .b_in      (b_in),
  .reg_a     (stored[0]),
  .reg_b     (stored[1]),
  .a_out     (a_out),
  .a_oe      (a_oe),
  .b_out     (b_out),
  .b_oe      (b_oe)
);

// File: tb/dual_reg_bus_xcvr_test.sv
module dual_reg_bus_xcvr_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         cap_a_clk = 1'b0, cap_b_clk = 1'b0;
  logic         rst = 1'b1, en_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [W-1:0] mdl_a = '0, mdl_b = '0;

  always #5 clk = ~clk;

  dual_reg_bus_xcvr #(.W(W)) uut (
    .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk), .rst(rst),
    .en_n(en_n), .dir(dir), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .b_in(b_in), .a_out(a_out), .a_oe(a_oe),
    .b_out(b_out), .b_oe(b_oe));

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // One vector: drive inputs, optionally pulse capture clocks, compare with the model.
  task automatic step(input logic e, input logic d, input logic sab, input logic sba,
                      input logic [W-1:0] av, input logic [W-1:0] bv,
                      input logic pa, input logic pb, input string tag);
    @(negedge clk);
    cap_a_clk = 1'b0; cap_b_clk = 1'b0;
    en_n = e; dir = d; sel_ab = sab; sel_ba = sba; a_in = av; b_in = bv;
    #2;
    if (pa) begin cap_a_clk = 1'b1; mdl_a = rst ? '0 : av; end
    if (pb) begin cap_b_clk = 1'b1; mdl_b = rst ? '0 : bv; end
    #2;
    chk({tag, " R4 b_out"}, b_out, sab ? mdl_a : av);
    chk({tag, " R5 a_out"}, a_out, sba ? mdl_b : bv);
    chk({tag, " R6 b_oe"},  {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, !e && d});
    chk({tag, " R7 a_oe"},  {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, !e && !d});
  endtask

  initial begin
    // R3: reset clears both registers; stored paths read 0.
    step(1, 0, 1, 1, 8'hFF, 8'hEE, 1, 1, "reset R3");
    rst = 1'b0;
    // R1 R2 R8: capture while outputs disabled, then read stored values.
    step(1, 1, 0, 0, 8'h3C, 8'hC3, 1, 1, "cap_off R8 R1 R2");
    step(1, 0, 1, 1, 8'h00, 8'h11, 0, 0, "read_stored R8");
    // Exhaustive control sweep with changing data and alternating captures.
    for (int i = 0; i < 64; i++) begin
      step(i[3], i[2], i[1], i[0], 8'(i * 37 + 5), 8'(~(i * 59)), i[4], i[5], "sweep R6 R7 R10");
    end
    // R9: toggle selects only, with data held; outputs follow immediately.
    step(0, 1, 0, 0, 8'hA5, 8'h5A, 1, 1, "sel_prep R9");
    step(0, 1, 1, 0, 8'h0F, 8'hF0, 0, 0, "sel_hi R9");
    step(0, 1, 0, 1, 8'h0F, 8'hF0, 0, 0, "sel_swap R9 R10");
    step(0, 0, 1, 1, 8'h0F, 8'hF0, 0, 0, "sel_both R9");
    // R3: reset seen only by clock A clears register A, keeps B.
    step(1, 0, 0, 0, 8'h77, 8'h88, 1, 1, "pre_rst R1 R2");
    rst = 1'b1;
    step(1, 0, 1, 1, 8'h12, 8'h34, 1, 0, "rst_a_only R3");
    rst = 1'b0;
    step(0, 0, 1, 1, 8'h56, 8'h9A, 0, 0, "after_rst R3");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule